// File: doc/BRIEF.md
# Receive Holding Buffer with Overrun Flag

This block sits between a serial receive shifter and the register read path of a serial port. Each completed character arrives as one byte with a one-cycle valid strobe. The block stores it and shows the current character on a read-only data output. A read strobe consumes that character. A data-ready output says whether a stored character is present. A sticky overrun output records that a character was lost or overwritten.

Bit 0 of the FIFO control input selects between two modes. With the bit clear, there is a single holding register, and a new byte replaces an unread one. With the bit set, a queue of `DEPTH` entries holds bytes in arrival order. When that queue is full, a new byte is thrown away and the queued bytes are kept. Any change of the mode bit empties the storage. The overrun flag is cleared only by the line-status read strobe.

Top module: `rx_hold_buf`

## Requirements
- R1: During and right after reset, `data_ready`, `overrun` and `rd_data` are all 0.
- R2: Only bit 0 of `fifo_ctl` matters (1 = queue mode, 0 = single-register mode). In a cycle where bit 0 differs from its value in the previous cycle, all stored bytes are discarded. A byte or read strobe arriving in that cycle is ignored. From the next cycle on, `data_ready` is 0.
- R3: In single-register mode, a byte arriving while nothing is stored is visible on `rd_data`, with `data_ready` set, in the cycle after its strobe.
- R4: In single-register mode, a byte arriving while an unread byte is stored and no read is strobed replaces that byte on `rd_data` and sets `overrun`.
- R5: In queue mode, up to `DEPTH` bytes are held, and reads return them oldest first.
- R6: In queue mode with `DEPTH` bytes stored and no read in the same cycle, an arriving byte is discarded. `rd_data` and the stored bytes do not change, and `overrun` is set. If a read and an arrival fall in the same cycle while the queue is full, the byte is accepted and no overrun occurs.
- R7: `overrun` stays set until a cycle with `lsr_rd` high clears it. An overrun event in that same cycle keeps it set.
- R8: `data_ready` falls in the cycle after the last stored byte is read. A read strobe while nothing is stored has no effect, and `rd_data` keeps showing the last byte read.
- R9: In single-register mode, a read and an arrival in the same cycle consume the old byte and keep the new one, without setting `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_ctl | input | 8 | FIFO control register value; bit 0 enables queue mode |
| rx_byte | input | DW | Byte from the receive shifter |
| rx_valid | input | 1 | One-cycle strobe: `rx_byte` holds a new character |
| rd_strobe | input | 1 | Read of the data register; consumes the current byte |
| lsr_rd | input | 1 | Line-status read; clears `overrun` |
| rd_data | output | DW | Current (oldest) byte, or the last byte read when empty |
| data_ready | output | 1 | A stored byte is present |
| overrun | output | 1 | Sticky flag: a byte was lost or overwritten |

## Verification
The assertions assume that `fifo_ctl`, `rx_valid`, `rd_strobe` and `lsr_rd` change only between clock edges, and that `rx_valid` is a known level every cycle after reset. They also assume that the clear check holds only when no byte arrives in the same cycle. The bench drives every input at the falling edge from known values. It toggles the mode bit rarely, so that stretches of full-queue and overwrite traffic occur. It combines reads, arrivals and status reads in every combination, in both modes.

// File: rtl/rx_hold_buf.sv
module rx_hold_buf #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    fifo_ctl,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_valid,
  input  logic          rd_strobe,
  input  logic          lsr_rd,
  output logic [DW-1:0] rd_data,
  output logic          data_ready,
  output logic          overrun
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt;
  logic [DW-1:0] last_q;
  logic          ovr_q, en_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + AW'(1);
  endfunction

  wire flush     = fifo_ctl[0] != en_q;
  wire empty     = cnt == '0;
  wire full      = cnt == FULL_CNT;
  wire pop       = rd_strobe && !empty && !flush;
  wire arrive    = rx_valid && !flush;
  wire q_push    = en_q && arrive && (!full || pop);
  wire q_drop    = en_q && arrive && full && !pop;
  wire s_write   = !en_q && arrive;
  wire s_clobber = s_write && !empty && !pop;
  wire ovr_evt   = q_drop || s_clobber;

  assign rd_data    = empty ? last_q : mem[rd_ptr];
  assign data_ready = !empty;
  assign overrun    = ovr_q;

  always_ff @(posedge clk) begin
    if (q_push)
      mem[wr_ptr] <= rx_byte;
    else if (s_write)
      mem[0] <= rx_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
      last_q <= '0;
      en_q   <= 1'b0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
      en_q   <= fifo_ctl[0];
    end else begin
      if (pop)
        last_q <= mem[rd_ptr];
      if (en_q) begin
        if (pop)
          rd_ptr <= bump(rd_ptr);
        if (q_push)
          wr_ptr <= bump(wr_ptr);
        if (q_push && !pop)
          cnt <= cnt + CW'(1);
        else if (pop && !q_push)
          cnt <= cnt - CW'(1);
      end else begin
        if (s_write)
          cnt <= CW'(1);
        else if (pop)
          cnt <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      ovr_q <= 1'b0;
    else if (ovr_evt)
      ovr_q <= 1'b1;
    else if (lsr_rd)
      ovr_q <= 1'b0;
  end
endmodule

module rx_hold_buf_chk #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [7:0]    fifo_ctl,
  input logic          rx_valid,
  input logic          rd_strobe,
  input logic          lsr_rd,
  input logic [DW-1:0] rd_data,
  input logic          data_ready,
  input logic          overrun,
  input logic [CW-1:0] cnt,
  input logic          en_q
);
  a_r5_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  a_r4_single_cap: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> cnt <= CW'(1));

  a_r2_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_ctl[0] != en_q) |=> !data_ready);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !lsr_rd |=> overrun);

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && lsr_rd && !rx_valid |=> !overrun);

  a_r6_full_keep: assert property (@(posedge clk) disable iff (!rst_n)
    en_q && fifo_ctl[0] && cnt == CW'(DEPTH) && rx_valid && !rd_strobe
      |=> overrun && data_ready && $stable(rd_data));

  a_r8_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    !data_ready && !rx_valid && fifo_ctl[0] == en_q
      |=> !data_ready && $stable(rd_data));
endmodule

bind rx_hold_buf rx_hold_buf_chk #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_ctl(fifo_ctl), .rx_valid(rx_valid),
  .rd_strobe(rd_strobe), .lsr_rd(lsr_rd), .rd_data(rd_data),
  .data_ready(data_ready), .overrun(overrun), .cnt(cnt), .en_q(en_q));

// File: tb/rx_hold_buf_bench.sv
module rx_hold_buf_bench;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] fifo_ctl = '0, rx_byte = '0;
  logic       rx_valid = 1'b0, rd_strobe = 1'b0, lsr_rd = 1'b0;
  logic [7:0] rd_data;
  logic       data_ready, overrun;

  always #10 clk = ~clk;

  rx_hold_buf #(.DEPTH(DEPTH), .DW(8)) u_rx_hold_buf (
    .clk(clk), .rst_n(rst_n), .fifo_ctl(fifo_ctl), .rx_byte(rx_byte),
    .rx_valid(rx_valid), .rd_strobe(rd_strobe), .lsr_rd(lsr_rd),
    .rd_data(rd_data), .data_ready(data_ready), .overrun(overrun));

  int    total = 0, bad = 0;
  string req = "R1";
  logic  cmp_on = 1'b0;

  logic [7:0] q[$];
  logic [7:0] m_last = '0;
  logic       m_ovr = 1'b0, m_en = 1'b0;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", r, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_last = '0; m_ovr = 1'b0; m_en = 1'b0;
    end else begin
      logic ev;
      ev = 1'b0;
      if (fifo_ctl[0] != m_en) begin
        q.delete(); m_en = fifo_ctl[0];
      end else begin
        logic pop;
        pop = rd_strobe && q.size() > 0;
        if (m_en) begin
          if (pop) m_last = q.pop_front();
          if (rx_valid) begin
            if (q.size() < DEPTH) q.push_back(rx_byte); else ev = 1'b1;
          end
        end else begin
          if (rx_valid && q.size() == 1 && !pop) begin
            q[0] = rx_byte; ev = 1'b1;
          end else begin
            if (pop) m_last = q.pop_front();
            if (rx_valid) q.push_back(rx_byte);
          end
        end
      end
      if (ev) m_ovr = 1'b1; else if (lsr_rd) m_ovr = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(req, data_ready, q.size() > 0, "data_ready");
      chk(req, rd_data, (q.size() > 0) ? q[0] : m_last, "rd_data");
      chk(req, overrun, m_ovr, "overrun");
    end
  end

  task automatic drv(input logic [7:0] c, input logic [7:0] b, input logic v, input logic r, input logic l);
    @(negedge clk);
    fifo_ctl = c; rx_byte = b; rx_valid = v; rd_strobe = r; lsr_rd = l;
  endtask

  task automatic idle(input logic [7:0] c);
    drv(c, 8'h00, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic settle;
    @(posedge clk); #1;
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", {data_ready, overrun}, 0, "flags in reset");
    chk("R1", rd_data, 0, "rd_data in reset");
    @(negedge clk); rst_n = 1'b1; cmp_on = 1'b1;
    settle();
    chk("R1", {data_ready, overrun, rd_data}, 0, "after reset");

    req = "R3";
    drv(8'h00, 8'h5A, 1, 0, 0); idle(8'h00); settle();
    chk("R3", {data_ready, rd_data}, {1'b1, 8'h5A}, "single store");
    req = "R4";
    drv(8'h00, 8'h22, 1, 0, 0); idle(8'h00); settle();
    chk("R4", {overrun, rd_data}, {1'b1, 8'h22}, "single overwrite");
    req = "R7";
    drv(8'h00, 8'h00, 0, 0, 0); settle();
    chk("R7", overrun, 1, "sticky");
    drv(8'h00, 8'h33, 1, 0, 1); idle(8'h00); settle();
    chk("R7", overrun, 1, "set beats clear");
    drv(8'h00, 8'h00, 0, 0, 1); idle(8'h00); settle();
    chk("R7", overrun, 0, "cleared by status read");
    req = "R9";
    drv(8'h00, 8'h44, 1, 1, 0); idle(8'h00); settle();
    chk("R9", {overrun, data_ready, rd_data}, {1'b0, 1'b1, 8'h44}, "read+arrive");
    req = "R8";
    drv(8'h00, 8'h00, 0, 1, 0); idle(8'h00); settle();
    chk("R8", {data_ready, rd_data}, {1'b0, 8'h44}, "last read");
    drv(8'h00, 8'h00, 0, 1, 0); idle(8'h00); settle();
    chk("R8", {data_ready, rd_data}, {1'b0, 8'h44}, "empty read no effect");

    req = "R2";
    drv(8'h00, 8'h66, 1, 0, 0);
    drv(8'hFE, 8'h77, 1, 0, 0); idle(8'hFE); settle();
    chk("R2", {data_ready, rd_data}, {1'b1, 8'h77}, "upper bits ignored");
    drv(8'h01, 8'h88, 1, 0, 0); idle(8'h01); settle();
    chk("R2", data_ready, 0, "mode change flushes");

    req = "R5";
    for (int i = 0; i < DEPTH; i++) drv(8'h01, 8'(8'h10 + i), 1, 0, 0);
    idle(8'h01); settle();
    chk("R5", {data_ready, rd_data}, {1'b1, 8'h10}, "full, oldest at head");
    req = "R6";
    drv(8'h01, 8'hEE, 1, 0, 0); idle(8'h01); settle();
    chk("R6", {overrun, rd_data}, {1'b1, 8'h10}, "full drop");
    drv(8'h01, 8'hD0, 1, 1, 1); idle(8'h01); settle();
    chk("R6", {overrun, rd_data}, {1'b0, 8'h11}, "full read+arrive accepted");
    req = "R5";
    for (int i = 0; i < DEPTH; i++) begin
      drv(8'h01, 8'h00, 0, 1, 0);
    end
    idle(8'h01); settle();
    chk("R5", {data_ready, rd_data}, {1'b0, 8'hD0}, "drained in order");
    req = "R8";
    drv(8'h01, 8'h00, 0, 1, 0); idle(8'h01); settle();
    chk("R8", {data_ready, rd_data}, {1'b0, 8'hD0}, "queue empty read");

    req = "R2";
    drv(8'h01, 8'h99, 1, 0, 0);
    drv(8'h00, 8'h00, 0, 1, 0); idle(8'h00); settle();
    chk("R2", {data_ready, rd_data}, {1'b0, 8'hD0}, "flush ignores read");

    req = "R6";
    begin
      logic [7:0] c;
      c = 8'h01;
      for (int n = 0; n < 4000; n++) begin
        if ($urandom_range(0, 127) == 0) c[0] = ~c[0];
        c[7:1] = 7'($urandom);
        drv(c, 8'($urandom), $urandom_range(0, 9) < 6, $urandom_range(0, 9) < 4,
            $urandom_range(0, 9) == 0);
      end
      idle(c);
      idle(c);
    end

    finish_run();
  end
endmodule